// File: doc/BRIEF.md
# Transmit Checksum Insertion Engine

This block sits in an Ethernet transmit path, between the stage that gathers frame bytes from descriptors and the stage that sends frames out. Each incoming byte carries the sideband of the descriptor it came from: a command byte, a checksum start offset, an insert offset and a VLAN tag value. The block stores the whole packet in an internal buffer. While the bytes arrive, it adds them into a 16-bit ones'-complement sum that runs from the start offset to the end of the packet. When the end-of-packet descriptor is complete, the block replays the packet on an output byte stream and writes the complemented sum at the insert offset.

Insertion is cancelled, without any signal, when the offsets do not fit inside the packet. The start offset comes from the first descriptor of a packet, and the insert offset, insert flag and VLAN flag come from the descriptor that ends the packet. When VLAN insertion is requested, the block adds a four-byte 802.1Q tag on output. The tag is left out of the sum, and all offsets count bytes of the untagged packet.

Top module: `tx_csum_insert`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: The inserted value is the bitwise complement of the 16-bit ones'-complement sum (end-around carry) of big-endian byte pairs. Pairs are formed from the start offset to the last byte, and a lone final byte is taken as the high half with a zero low half. The two bytes already at the insert offset (the seed) are part of the sum. The result replaces them, high byte at the insert offset and low byte at the next offset. All other bytes leave unchanged and in order.
- R3: The start offset is taken from `in_css` with the first byte of a packet only. `in_css` on every later byte, including the first byte of later descriptors, has no effect.
- R4: A descriptor ends at a byte with `in_last` set. It is the end-of-packet descriptor when `in_cmd` bit 0 is set on that byte. `in_cso`, insert-flag `in_cmd` bit 2 and VLAN-enable `in_cmd` bit 6 are used only from that byte. Bits 1, 3, 4, 5 and 7 are ignored.
- R5: Offsets count bytes from the first byte of the packet, starting at 0. With L the stored packet length, no byte is changed when start >= L or insert offset >= L-1, or when the insert flag is 0.
- R6: When VLAN-enable is set and L >= 12, the output carries bytes 0x81, 0x00, tag[15:8], tag[7:0] at output positions 12 to 15, followed by packet byte 12 onward. These bytes are not in the sum, and offsets keep referring to the untagged packet. When L < 12, no tag is added.
- R7: Output of a packet starts only after its end-of-packet byte is accepted. From the cycle after that byte until the cycle after the last output byte is accepted, `in_ready` is 0. `out_last` is 1 only on the final output byte.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values.
- R9: Bytes beyond MAX_LEN (default 1522) in a packet are accepted and discarded. They are neither stored nor summed, and L saturates at MAX_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Last byte of the current descriptor |
| in_cmd | input | 8 | Descriptor command byte (bit 0 end-of-packet, bit 2 insert, bit 6 VLAN) |
| in_css | input | OFS_W | Checksum start offset |
| in_cso | input | OFS_W | Checksum insert offset |
| in_vtag | input | 16 | VLAN tag value to insert |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts output byte |
| out_data | output | 8 | Output frame byte |
| out_last | output | 1 | Last byte of the output packet |

## Verification
Some sideband is valid on one descriptor and must be ignored on the others. To reach that case, the bench splits packets across several descriptors. The non-final descriptors carry conflicting start offsets, a set insert flag, a set VLAN flag and a wrong insert offset, so any use of the wrong descriptor shows up in the output bytes. The oversized packet runs past the buffer cap and places the insert offset just below the capped length, which tests truncation and the range check together. Random downstream stalls test that held output bytes stay stable.

// File: rtl/tx_csum_pkg.sv
package tx_csum_pkg;
  localparam int CMD_EOP_BIT = 0;
  localparam int CMD_INS_BIT = 2;
  localparam int CMD_VLE_BIT = 6;
  localparam int TAG_AT      = 12;
  localparam int TAG_BYTES   = 4;
  localparam logic [15:0] TAG_TYPE = 16'h8100;

  typedef enum logic [1:0] {
    EM_IDLE,
    EM_ADDR,
    EM_LOAD,
    EM_WAIT
  } em_state_t;
endpackage

// File: rtl/tx_csum_accum.sv
module tx_csum_accum #(
  parameter int IW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic [IW-1:0] idx,
  input  logic [IW-1:0] start,
  input  logic [7:0]    data,
  output logic [15:0]   sum
);
  logic [15:0] addend;
  logic [16:0] total;
  logic [15:0] folded;

  // position parity relative to start selects the high or low half
  always_comb begin
    addend = (idx[0] ^ start[0]) ? {8'h00, data} : {data, 8'h00};
    total  = {1'b0, sum} + {1'b0, addend};
    folded = total[15:0] + {15'd0, total[16]};
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      sum <= 16'h0000;
    else if (en && (idx >= start))
      sum <= folded;
  end
endmodule

// File: rtl/tx_csum_buf.sv
module tx_csum_buf #(
  parameter int DEPTH = 1522,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re)
      rdata <= mem[raddr];
  end
endmodule

// File: rtl/tx_csum_emit.sv
module tx_csum_emit
  import tx_csum_pkg::*;
#(
  parameter int IW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [IW-1:0] len,
  input  logic          tag_on,
  input  logic [15:0]   vtag,
  input  logic [IW-1:0] ins_at,
  input  logic          ins_ok,
  input  logic [15:0]   csum,
  input  logic [7:0]    rdata,
  output logic          re,
  output logic [IW-1:0] raddr,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          done
);
  localparam int LW = IW + 1;

  em_state_t     st;
  logic [LW-1:0] pos;
  logic [LW-1:0] olen;
  logic [LW-1:0] bidx;
  logic [LW-1:0] tpos;
  logic          in_tag;
  logic [7:0]    nxt_byte;

  always_comb begin
    olen   = {1'b0, len} + (tag_on ? LW'(TAG_BYTES) : LW'(0));
    bidx   = (tag_on && pos >= LW'(TAG_AT + TAG_BYTES)) ? pos - LW'(TAG_BYTES) : pos;
    tpos   = pos - LW'(TAG_AT);
    in_tag = tag_on && (pos >= LW'(TAG_AT)) && (pos < LW'(TAG_AT + TAG_BYTES));
    raddr  = bidx[IW-1:0];
    re     = (st == EM_ADDR);
    done   = (st == EM_WAIT) && out_ready && out_last;
  end

  always_comb begin
    nxt_byte = rdata;
    if (in_tag) begin
      if (tpos == LW'(0))      nxt_byte = TAG_TYPE[15:8];
      else if (tpos == LW'(1)) nxt_byte = TAG_TYPE[7:0];
      else if (tpos == LW'(2)) nxt_byte = vtag[15:8];
      else                     nxt_byte = vtag[7:0];
    end else if (ins_ok && bidx == {1'b0, ins_at}) begin
      nxt_byte = csum[15:8];
    end else if (ins_ok && bidx == ({1'b0, ins_at} + LW'(1))) begin
      nxt_byte = csum[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= EM_IDLE;
      pos       <= '0;
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      out_last  <= 1'b0;
    end else begin
      case (st)
        EM_IDLE: begin
          pos <= '0;
          if (go) st <= EM_ADDR;
        end
        EM_ADDR: st <= EM_LOAD;
        EM_LOAD: begin
          out_valid <= 1'b1;
          out_data  <= nxt_byte;
          out_last  <= (pos == olen - LW'(1));
          st        <= EM_WAIT;
        end
        EM_WAIT: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            pos       <= pos + LW'(1);
            st        <= out_last ? EM_IDLE : EM_ADDR;
          end
        end
        default: st <= EM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_csum_insert.sv
module tx_csum_insert
  import tx_csum_pkg::*;
#(
  parameter int MAX_LEN = 1522,
  parameter int OFS_W   = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic [7:0]       in_cmd,
  input  logic [OFS_W-1:0] in_css,
  input  logic [OFS_W-1:0] in_cso,
  input  logic [15:0]      in_vtag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last
);
  localparam int IW = OFS_W;
  localparam int LW = IW + 1;

  logic          busy;
  logic          sop;
  logic          go;
  logic [IW-1:0] len_q;
  logic [IW-1:0] css_q;
  logic [IW-1:0] cso_q;
  logic          ins_q;
  logic          vle_q;
  logic [15:0]   vtag_q;

  logic          fire;
  logic          room;
  logic          eop_byte;
  logic [IW-1:0] css_eff;
  logic [15:0]   sum;
  logic          ins_ok;
  logic          tag_on;
  logic          done;
  logic          rd_en;
  logic [IW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          cmd_unused;

  assign cmd_unused = ^{in_cmd[7], in_cmd[5:3], in_cmd[1]};

  always_comb begin
    in_ready = ~busy;
    fire     = in_valid && ~busy;
    room     = len_q < IW'(MAX_LEN);
    eop_byte = in_last && in_cmd[CMD_EOP_BIT];
    css_eff  = sop ? in_css : css_q;
    ins_ok   = ins_q && ({1'b0, css_q} < {1'b0, len_q})
                     && (({1'b0, cso_q} + LW'(1)) < {1'b0, len_q});
    tag_on   = vle_q && (len_q >= IW'(TAG_AT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      sop    <= 1'b1;
      go     <= 1'b0;
      len_q  <= '0;
      css_q  <= '0;
      cso_q  <= '0;
      ins_q  <= 1'b0;
      vle_q  <= 1'b0;
      vtag_q <= 16'h0000;
    end else begin
      go <= 1'b0;
      if (fire) begin
        if (room) len_q <= len_q + IW'(1);
        if (sop) begin
          css_q <= in_css;
          sop   <= 1'b0;
        end
        if (eop_byte) begin
          busy   <= 1'b1;
          go     <= 1'b1;
          cso_q  <= in_cso;
          ins_q  <= in_cmd[CMD_INS_BIT];
          vle_q  <= in_cmd[CMD_VLE_BIT];
          vtag_q <= in_vtag;
        end
      end
      if (done) begin
        busy  <= 1'b0;
        sop   <= 1'b1;
        len_q <= '0;
      end
    end
  end

  tx_csum_accum #(.IW(IW)) u_accum (
    .clk   (clk),
    .rst   (rst),
    .clr   (done),
    .en    (fire && room),
    .idx   (len_q),
    .start (css_eff),
    .data  (in_data),
    .sum   (sum)
  );

  tx_csum_buf #(.DEPTH(MAX_LEN), .AW(IW)) u_buf (
    .clk   (clk),
    .we    (fire && room),
    .waddr (len_q),
    .wdata (in_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  tx_csum_emit #(.IW(IW)) u_emit (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .len       (len_q),
    .tag_on    (tag_on),
    .vtag      (vtag_q),
    .ins_at    (cso_q),
    .ins_ok    (ins_ok),
    .csum      (~sum),
    .rdata     (rd_data),
    .re        (rd_en),
    .raddr     (rd_addr),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .done      (done)
  );
endmodule

// File: rtl/tx_csum_insert_chk.sv
module tx_csum_insert_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last
);
  // R1
  rst_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !out_valid));

  // R7
  no_accept_while_sending_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R7
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R7
  release_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

bind tx_csum_insert tx_csum_insert_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last)
);

// File: tb/tx_csum_insert_tb.sv
module tx_csum_insert_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_LEN    = 1522;
  localparam int IW         = 11;

  typedef logic [7:0] bytes_t[];

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_data = 8'h00;
  logic          in_last = 1'b0;
  logic [7:0]    in_cmd = 8'h00;
  logic [IW-1:0] in_css = '0;
  logic [IW-1:0] in_cso = '0;
  logic [15:0]   in_vtag = 16'h0000;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [7:0]    out_data;
  logic          out_last;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   bp_on = 1'b0;
  logic [8:0] exp_q[$];
  string      req_q[$];

  tx_csum_insert #(.MAX_LEN(MAX_LEN), .OFS_W(IW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_cmd(in_cmd), .in_css(in_css),
    .in_cso(in_cso), .in_vtag(in_vtag), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: scoreboard compare of every accepted output byte
  always @(negedge clk) begin
    if (rst) out_ready = 1'b0;
    else begin
      out_ready = bp_on ? ($urandom_range(0, 3) != 0) : 1'b1;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0)
          check(1'b0, "R7", "unexpected output byte", {23'd0, out_last, out_data}, 0);
        else begin
          logic [8:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check({out_last, out_data} === e, r, "{last,data}", {23'd0, out_last, out_data}, {23'd0, e});
        end
      end
    end
  end

  function automatic bytes_t mk(input int n, input int seed);
    bytes_t p;
    p = new[n];
    for (int i = 0; i < n; i++) p[i] = 8'((i * 37) + (i >> 3) * 11 + seed);
    return p;
  endfunction

  task automatic send_pkt(input bytes_t p, input int nd, input int css, input int cso,
                          input bit ins, input bit vle, input logic [15:0] tag,
                          input bit bp, input string req);
    int n;
    int len;
    logic [16:0] s;
    logic [15:0] res;
    bit ok;
    logic [7:0] o[$];
    logic [7:0] t[$];
    n   = p.size();
    len = (n > MAX_LEN) ? MAX_LEN : n;
    s = 17'd0;
    for (int i = css; i < len; i++) begin
      s = s + (((i - css) % 2 == 0) ? {1'b0, p[i], 8'h00} : {9'd0, p[i]});
      s = {1'b0, s[15:0]} + {16'd0, s[16]};
    end
    res = ~s[15:0];
    ok  = ins && (css < len) && (cso < len - 1);
    for (int i = 0; i < len; i++) o.push_back(p[i]);
    if (ok) begin
      o[cso]     = res[15:8];
      o[cso + 1] = res[7:0];
    end
    if (vle && len >= 12) begin
      for (int i = 0; i < len; i++) begin
        if (i == 12) begin
          t.push_back(8'h81); t.push_back(8'h00);
          t.push_back(tag[15:8]); t.push_back(tag[7:0]);
        end
        t.push_back(o[i]);
      end
    end else t = o;
    for (int i = 0; i < t.size(); i++) begin
      exp_q.push_back({(i == t.size() - 1), t[i]});
      req_q.push_back(req);
    end
    bp_on = bp;
    for (int i = 0; i < n; i++) begin
      int d;
      bit lastd;
      d     = (i * nd) / n;
      lastd = (d == nd - 1);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = p[i];
      in_last  = (i == (((d + 1) * n) / nd) - 1);
      in_cmd   = lastd ? (8'h09 | {1'b0, vle, 3'b000, ins, 2'b00}) : 8'hC6;
      in_css   = (i == 0) ? IW'(css) : IW'(css + 7);
      in_cso   = lastd ? IW'(cso) : IW'(3);
      in_vtag  = lastd ? tag : 16'hFFFF;
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    check(in_ready == 1'b0, "R7", "in_ready after end of packet", in_ready, 0);
    while (!in_ready) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    // R2 single descriptor, seed in place
    send_pkt(mk(40, 5), 1, 14, 30, 1, 0, 16'h0, 0, "R2");
    // R3/R4 odd length over three descriptors with conflicting sideband
    send_pkt(mk(61, 9), 3, 20, 36, 1, 0, 16'h0, 1, "R3_R4");
    // R5 start offset equals length
    send_pkt(mk(30, 2), 1, 30, 4, 1, 0, 16'h0, 0, "R5");
    // R5 insert offset at length-1: suppressed
    send_pkt(mk(30, 3), 1, 0, 29, 1, 0, 16'h0, 0, "R5");
    // R5 insert offset at length-2: inserted
    send_pkt(mk(30, 4), 2, 0, 28, 1, 0, 16'h0, 0, "R5");
    // R4 insert flag only on non-final descriptor
    send_pkt(mk(50, 7), 2, 10, 20, 0, 0, 16'h0, 0, "R4");
    // R6 VLAN tag added and kept out of the sum
    send_pkt(mk(64, 1), 2, 34, 50, 1, 1, 16'hA05C, 1, "R6");
    // R6 packet too short for a tag
    send_pkt(mk(10, 6), 1, 2, 6, 1, 1, 16'h1234, 0, "R6");
    // R9 oversized packet, insert just below the cap, with stalls (R8)
    send_pkt(mk(1530, 8), 3, 14, 1520, 1, 0, 16'h0, 1, "R9_R8");
    while (exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule